// File: doc/BRIEF.md
# Noise Voice with Recirculating Ring

This block makes the 1-bit noise stream of one sound voice. A 7-bit down-counter divides a tone-rate enable pulse. Each time the counter wraps, a 16-bit linear feedback shift register steps once. The LFSR's top bit does not drive the output. A rising edge on that bit clocks an 8-bit twisted ring, which is the same recirculating structure the tone voices use. The ring's most significant bit is the voice's serial output, and it goes on to a four-input audio mix outside this block.

While the voice is enabled, each ring step feeds back the complement of the ring's top bit. While the voice is disabled, steps still happen but shift in zeros. The ring is never cleared when the enable changes. A disable that lasts only part of a ring cycle can therefore leave a non-square bit pattern in the ring. That pattern keeps circulating after the voice is enabled again and alters the timbre for as long as it remains.

Top module: `noise_voice`

## Requirements
- R1: While `rst` is high at a clock edge, the divider count is set to 0, the LFSR is set to the nonzero seed 16'hACE1 and the ring is cleared, so `noise_out` reads 0 after that edge.
- R2: The divider changes only on cycles where `tick_en` is high. With `tick_en` high and the count at 0, the count reloads from `freq` and the LFSR steps once. With `tick_en` high and the count nonzero, the count decrements. The LFSR therefore steps once per `freq`+1 enable pulses, and it never steps without an enable pulse.
- R3: On each step the LFSR shifts toward its most significant bit. The new bit 0 is the XOR of bits 15, 14, 12 and 3 (zero-based, polynomial x^16+x^15+x^13+x^4+1). The state never becomes zero, and the sequence repeats every 65535 steps.
- R4: The ring shifts only on an LFSR step in which bit 15 goes from 0 to 1, which is when the old bit 14 is 1 and the old bit 15 is 0. Every other cycle leaves the ring unchanged.
- R5: On a ring shift with `voice_on` high, the ring moves one place toward its MSB and takes the complement of its old MSB into bit 0.
- R6: On a ring shift with `voice_on` low, the ring moves one place toward its MSB and takes 0 into bit 0. Changing `voice_on` never clears or alters the ring by itself, so a partial pattern stays trapped.
- R7: `noise_out` equals the ring's bit 7, registered, and changes in the same clock edge as the ring shift that sets it.
- R8: A new `freq` value takes effect only at the next reload. A count already running finishes with its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Tone-rate enable pulse that advances the divider |
| freq | input | 7 | Divider reload value; the LFSR steps every freq+1 pulses |
| voice_on | input | 1 | Voice enable; selects the ring feedback bit |
| noise_out | output | 1 | Serial noise bit, the ring's MSB |

## Verification
All internal state shows up at `noise_out`, and in most cases it shows up late. A wrong divider length or a wrong LFSR tap changes which steps produce a rising LFSR edge. That appears as a shifted or missing `noise_out` transition within a few ring shifts. A wrong ring feedback or a clear on enable gives a wrong output bit within at most eight ring shifts, because that is how long a bit takes to reach the MSB. A lockstep model compared on every cycle catches these differences. A repetition test at the full 65535-step period catches a non-maximal tap set.

// File: rtl/noise_pkg.sv
package noise_pkg;
    localparam int LFSR_W = 16;
    localparam int RING_W = 8;
    localparam int FREQ_W = 7;

    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hD008;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef struct packed {
        logic step;
        logic edge_up;
    } lfsr_evt_t;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
    endfunction

    function automatic logic lfsr_rises(input logic [LFSR_W-1:0] s);
        return (!s[LFSR_W-1]) && s[LFSR_W-2];
    endfunction
endpackage

// File: rtl/noise_rate_div.sv
module noise_rate_div #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic [W-1:0] reload,
    output logic         wrap
);
    logic [W-1:0] count_q;

    assign wrap = tick_en && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (tick_en) begin
            if (count_q == '0) count_q <= reload;
            else               count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
    import noise_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [LFSR_W-1:0] state,
    output lfsr_evt_t         evt
);
    always_ff @(posedge clk) begin
        if (rst)          state <= LFSR_SEED;
        else if (advance) state <= lfsr_next(state);
    end

    assign evt.step    = advance;
    assign evt.edge_up = advance && lfsr_rises(state);
endmodule

// File: rtl/noise_ring.sv
module noise_ring #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         enable,
    output logic [W-1:0] ring
);
    logic feed;

    assign feed = enable ? ~ring[W-1] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst)        ring <= '0;
        else if (shift) ring <= {ring[W-2:0], feed};
    end
endmodule

// File: rtl/noise_voice.sv
module noise_voice
    import noise_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [FREQ_W-1:0] freq,
    input  logic              voice_on,
    output logic              noise_out
);
    logic              div_wrap;
    logic [LFSR_W-1:0] lfsr_state;
    lfsr_evt_t         lfsr_evt;
    logic [RING_W-1:0] ring_state;

    noise_rate_div #(.W(FREQ_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .reload  (freq),
        .wrap    (div_wrap)
    );

    noise_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .advance (div_wrap),
        .state   (lfsr_state),
        .evt     (lfsr_evt)
    );

    noise_ring #(.W(RING_W)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .shift   (lfsr_evt.edge_up),
        .enable  (voice_on),
        .ring    (ring_state)
    );

    assign noise_out = ring_state[RING_W-1];
endmodule

// File: rtl/noise_voice_chk.sv
module noise_voice_chk
    import noise_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              voice_on,
    input logic [LFSR_W-1:0] lfsr_q,
    input logic [RING_W-1:0] ring_q
);
    AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (lfsr_q == LFSR_SEED && ring_q == '0)); // R1
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(tick_en)) |-> ($stable(lfsr_q) && $stable(ring_q))); // R2
    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst) lfsr_q != '0); // R3
    AST_RING_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && ring_q != $past(ring_q)) |-> $rose(lfsr_q[LFSR_W-1])); // R4
    AST_RING_TWIST_ON: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $rose(lfsr_q[LFSR_W-1]) && $past(voice_on)) |-> ring_q == {$past(ring_q[RING_W-2:0]), ~$past(ring_q[RING_W-1])}); // R5
    AST_RING_ZERO_OFF: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $rose(lfsr_q[LFSR_W-1]) && !$past(voice_on)) |-> ring_q == {$past(ring_q[RING_W-2:0]), 1'b0}); // R6
endmodule

bind noise_voice noise_voice_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .voice_on (voice_on),
    .lfsr_q   (lfsr_state),
    .ring_q   (ring_state)
);

// File: tb/noise_voice_test.sv
module noise_voice_test;
    localparam int CLK_HALF = 5;
    localparam int WATCHDOG = 190000;
    localparam logic [15:0] SEED = 16'hACE1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [6:0] freq = 7'd0;
    logic       voice_on = 1'b0;
    logic       noise_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model built from the requirements
    logic [6:0]  m_cnt = 7'd0;
    logic [15:0] m_lfsr = SEED;
    logic [7:0]  m_ring = 8'd0;

    noise_voice uut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .freq      (freq),
        .voice_on  (voice_on),
        .noise_out (noise_out)
    );

    always #CLK_HALF clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_cnt  <= 7'd0;
            m_lfsr <= SEED;
            m_ring <= 8'd0;
        end else if (tick_en) begin
            if (m_cnt == 7'd0) begin
                m_cnt  <= freq;
                m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[14] ^ m_lfsr[12] ^ m_lfsr[3]};
                if (!m_lfsr[15] && m_lfsr[14])
                    m_ring <= {m_ring[6:0], voice_on ? ~m_ring[7] : 1'b0};
            end else begin
                m_cnt <= m_cnt - 7'd1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // advance n cycles, pulsing tick_en every 'every' cycles, comparing each cycle
    task automatic run(input int n, input int every, input string req);
        for (int i = 0; i < n; i++) begin
            tick_en = (every > 0) && ((i % every) == 0);
            @(negedge clk);
            check(noise_out == m_ring[7], req, noise_out, m_ring[7]);
        end
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; tick_en = 1'b1; voice_on = 1'b1;
        repeat (3) @(negedge clk);
        check(noise_out == 1'b0, "R1 reset output", noise_out, 0);
        rst = 1'b0;
        run(4, 0, "R1 idle after reset");
        check(noise_out == 1'b0, "R1 ring clear", noise_out, 0);
    endtask

    task automatic t_no_tick();
        voice_on = 1'b1; freq = 7'd0;
        run(300, 0, "R2 no tick no change");
        check(noise_out == 1'b0, "R2 output held without ticks", noise_out, 0);
    endtask

    task automatic t_divider();
        voice_on = 1'b1;
        freq = 7'd3;   run(2000, 1, "R2 divide by 4");
        freq = 7'd10;  run(3000, 3, "R2 sparse ticks divide by 11");
        freq = 7'd127; run(3000, 1, "R2 divide by 128");
        // change mid-count: old length must finish first
        freq = 7'd2;   run(1500, 1, "R8 reload takes new value");
        freq = 7'd0;   run(50, 1, "R8 switch to full rate");
    endtask

    task automatic t_twist();
        int toggles = 0;
        logic prev;
        voice_on = 1'b1; freq = 7'd0;
        prev = noise_out;
        for (int i = 0; i < 4000; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            check(noise_out == m_ring[7], "R5 twisted ring stream", noise_out, m_ring[7]);
            if (noise_out != prev) toggles++;
            prev = noise_out;
        end
        tick_en = 1'b0;
        check(toggles > 0, "R4 output toggles on LFSR rises", toggles, 1);
    endtask

    task automatic t_period();
        logic [511:0] first;
        logic [511:0] later;
        voice_on = 1'b1; freq = 7'd0;
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 512; i++) begin
            tick_en = 1'b1; @(negedge clk); first[i] = noise_out;
        end
        run(65535 - 512, 1, "R3 long run");
        for (int i = 0; i < 512; i++) begin
            tick_en = 1'b1; @(negedge clk); later[i] = noise_out;
        end
        tick_en = 1'b0;
        check(first == later, "R3 stream repeats after 65535 steps", int'(first[31:0]), int'(later[31:0]));
        check(first != '0, "R3 stream not stuck", int'(first[31:0]), 1);
    endtask

    task automatic t_trap();
        logic held;
        voice_on = 1'b1; freq = 7'd0;
        run(37, 1, "R5 fill ring");
        voice_on = 1'b0;
        run(23, 1, "R6 disabled shifts zeros");
        voice_on = 1'b1;
        run(500, 1, "R6 trapped pattern circulates");
        held = noise_out;
        for (int i = 0; i < 20; i++) begin
            voice_on = ~voice_on;
            @(negedge clk);
            check(noise_out == held, "R6 enable toggle keeps ring", noise_out, held);
        end
        voice_on = 1'b1;
        run(800, 1, "R6 resume after toggles");
        voice_on = 1'b0;
        run(2000, 1, "R6 disabled drains to zero");
        check(noise_out == 1'b0, "R6 zeros reach output", noise_out, 0);
        check(noise_out == m_ring[7], "R7 output is ring msb", noise_out, m_ring[7]);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_no_tick();
        t_divider();
        t_twist();
        t_trap();
        t_period();
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < WATCHDOG) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule